// File: doc/BRIEF.md
# Audio Link Sample FIFO and DMA Request Controller

This block sits between a DMA engine and the slot logic of a serial audio link. It holds one outgoing and one incoming queue of 32-bit samples. The DMA engine fills the outgoing queue and empties the incoming one through plain strobe-and-data ports. The link side takes outgoing samples one slot at a time and hands in received samples. The block raises one request line per direction at fixed occupancy thresholds, so the DMA engine knows when to move data. No software-visible register reports fill levels or request state.

A software-owned enable bit, `cold_rst_en`, governs the whole unit. While it is clear, the external codec reset stays asserted and every register is held cleared. Once the bit is set, the outgoing link stream carries zero samples until the outgoing queue has first reached half full. Only then does real data flow. Incoming slots that the codec has not marked valid are stored as zeros.

Top module: `audio_fifo_dma_ctrl`

## Requirements
- R1: `dma_tx_req` is a registered output. One clock edge after the outgoing queue holds fewer than 32 bytes (fewer than 8 entries of 4 bytes), it reads 1, and one edge after the queue holds 32 bytes or more, it reads 0. No input changes this threshold.
- R2: `dma_rx_req` is a registered output. One clock edge after the incoming queue holds 32 bytes or more (8 or more entries), it reads 1, and otherwise it reads 0.
- R3: While `cold_rst_en` is 0, `codec_rst_n` reads 0 from the next edge on. Both queues are emptied, `dma_tx_req`, `dma_rx_req`, `link_tx_underrun` and `link_rx_overrun` read 0, and `dma_rx_rdata` reads 0. This also applies when the bit is cleared during operation.
- R4: After release, while the outgoing queue has not yet reached 8 entries, a `link_tx_take` returns `link_tx_sample` = 0, consumes nothing and does not flag underrun. Streaming starts at the edge after the count first reaches 8 and stays on until the next reset.
- R5: Once streaming, a `link_tx_take` presents the oldest outgoing entry on `link_tx_sample` in the same cycle and removes it at the edge. Entries leave in write order.
- R6: A `link_tx_take` while streaming with an empty outgoing queue returns 0 and sets `link_tx_underrun` at the next edge. The flag then stays set until reset.
- R7: A `link_rx_put` stores `link_rx_sample` when `link_rx_valid` is 1 and stores 0 when it is 0.
- R8: A `link_rx_put` into a full incoming queue (16 entries) without a same-cycle `dma_rx_rd` drops the sample. It sets the sticky `link_rx_overrun` at the next edge.
- R9: A same-cycle push and pop on one queue leaves its count unchanged. At full, such a push is accepted and raises no overrun.
- R10: A `dma_tx_wr` into a full outgoing queue (16 entries) with no same-cycle pop is dropped silently.
- R11: `dma_rx_rd` on an empty incoming queue is ignored, and `dma_rx_rdata` reads 0 whenever that queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| cold_rst_en | input | 1 | Software cold-reset release bit; 0 holds the unit in reset |
| codec_rst_n | output | 1 | External codec reset, active low |
| dma_tx_wr | input | 1 | DMA write strobe into the outgoing queue |
| dma_tx_wdata | input | 32 | DMA write data |
| dma_tx_req | output | 1 | DMA request to refill the outgoing queue |
| dma_rx_rd | input | 1 | DMA read strobe from the incoming queue |
| dma_rx_rdata | output | 32 | Oldest incoming entry, 0 when empty |
| dma_rx_req | output | 1 | DMA request to drain the incoming queue |
| link_tx_take | input | 1 | Link slot asks for one outgoing sample |
| link_tx_sample | output | 32 | Outgoing sample for the slot |
| link_tx_underrun | output | 1 | Sticky outgoing underrun flag |
| link_rx_put | input | 1 | Link slot delivers one incoming sample |
| link_rx_valid | input | 1 | Codec marks the delivered sample valid |
| link_rx_sample | input | 32 | Incoming sample data |
| link_rx_overrun | output | 1 | Sticky incoming overrun flag |

## Verification
On each queue, the DMA port and the link port can act in the same cycle: a DMA write with a slot take on the outgoing side, and a slot put with a DMA read on the incoming side. The bench raises a put and a read together while the incoming queue sits exactly at its 8-entry threshold and again while it is full. It judges the outcome by a request line that does not toggle, by an overrun flag that stays clear, and by the exact order of data drained afterwards against a queue model kept in the bench.

// File: rtl/afd_pkg.sv
package afd_pkg;
  // Fixed DMA thresholds in bytes; not programmable.
  localparam int unsigned AFD_TX_THR_BYTES = 32;
  localparam int unsigned AFD_RX_THR_BYTES = 32;

  // Outgoing side wants a refill below the threshold.
  function automatic logic afd_tx_hungry(int unsigned entries, int unsigned bytes_per_entry);
    return (entries * bytes_per_entry) < AFD_TX_THR_BYTES;
  endfunction

  // Incoming side wants draining at or above the threshold.
  function automatic logic afd_rx_loaded(int unsigned entries, int unsigned bytes_per_entry);
    return (entries * bytes_per_entry) >= AFD_RX_THR_BYTES;
  endfunction
endpackage

// File: rtl/afd_fifo.sv
module afd_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign head    = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else if (srst) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_push_pop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (push_ok && pop_ok) |=> $stable(count));
endmodule

// File: rtl/afd_tx_gate.sv
module afd_tx_gate #(
  parameter int W    = 32,
  parameter int CW   = 5,
  parameter int HALF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          take,
  input  logic [CW-1:0] count,
  input  logic          empty,
  input  logic [W-1:0]  head,
  output logic          pop,
  output logic [W-1:0]  sample,
  output logic          underrun
);
  logic streaming, starve;

  assign pop    = take && streaming && !empty;
  assign starve = take && streaming && empty;
  assign sample = pop ? head : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streaming <= 1'b0; underrun <= 1'b0;
    end else if (srst) begin
      streaming <= 1'b0; underrun <= 1'b0;
    end else begin
      if (count >= CW'(HALF)) streaming <= 1'b1;
      if (starve)             underrun  <= 1'b1;
    end
  end

  assert_stream_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n || srst)
    streaming |=> streaming);
  assert_quiet_prestream_R4: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (!streaming && !underrun) |=> !underrun);
  assert_underrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n || srst)
    starve |=> underrun);
  assert_underrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n || srst)
    underrun |=> underrun);
endmodule

// File: rtl/afd_rx_gate.sv
module afd_rx_gate #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic         put,
  input  logic         valid,
  input  logic [W-1:0] data,
  input  logic         full,
  input  logic         pop_ok,
  output logic         push,
  output logic [W-1:0] push_data,
  output logic         overrun
);
  logic drop;

  assign push      = put;
  assign push_data = valid ? data : '0;
  assign drop      = put && full && !pop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      overrun <= 1'b0;
    else if (srst)   overrun <= 1'b0;
    else if (drop)   overrun <= 1'b1;
  end

  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n || srst)
    drop |=> overrun);
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n || srst)
    overrun |=> overrun);
endmodule

// File: rtl/audio_fifo_dma_ctrl.sv
module audio_fifo_dma_ctrl #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int BYTES = W / 8,
  localparam int HALF  = DEPTH / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cold_rst_en,
  output logic         codec_rst_n,
  input  logic         dma_tx_wr,
  input  logic [W-1:0] dma_tx_wdata,
  output logic         dma_tx_req,
  input  logic         dma_rx_rd,
  output logic [W-1:0] dma_rx_rdata,
  output logic         dma_rx_req,
  input  logic         link_tx_take,
  output logic [W-1:0] link_tx_sample,
  output logic         link_tx_underrun,
  input  logic         link_rx_put,
  input  logic         link_rx_valid,
  input  logic [W-1:0] link_rx_sample,
  output logic         link_rx_overrun
);
  import afd_pkg::*;

  logic srst;
  assign srst = !cold_rst_en;

  // Outgoing path
  logic [W-1:0]  tx_head;
  logic [CW-1:0] tx_count;
  logic tx_full, tx_empty, tx_push_ok, tx_pop_ok, tx_pop;

  afd_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk, .rst_n, .srst,
    .push(dma_tx_wr), .push_data(dma_tx_wdata), .pop(tx_pop),
    .head(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok));

  afd_tx_gate #(.W(W), .CW(CW), .HALF(HALF)) u_tx_gate (
    .clk, .rst_n, .srst,
    .take(link_tx_take), .count(tx_count), .empty(tx_empty), .head(tx_head),
    .pop(tx_pop), .sample(link_tx_sample), .underrun(link_tx_underrun));

  // Incoming path
  logic [W-1:0]  rx_push_data;
  logic [CW-1:0] rx_count;
  logic rx_full, rx_empty, rx_push_ok, rx_pop_ok, rx_push;

  afd_rx_gate #(.W(W)) u_rx_gate (
    .clk, .rst_n, .srst,
    .put(link_rx_put), .valid(link_rx_valid), .data(link_rx_sample),
    .full(rx_full), .pop_ok(rx_pop_ok),
    .push(rx_push), .push_data(rx_push_data), .overrun(link_rx_overrun));

  afd_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk, .rst_n, .srst,
    .push(rx_push), .push_data(rx_push_data), .pop(dma_rx_rd),
    .head(dma_rx_rdata), .count(rx_count), .full(rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok));

  // Codec reset and registered DMA requests
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codec_rst_n <= 1'b0; dma_tx_req <= 1'b0; dma_rx_req <= 1'b0;
    end else begin
      codec_rst_n <= cold_rst_en;
      if (srst) begin
        dma_tx_req <= 1'b0; dma_rx_req <= 1'b0;
      end else begin
        dma_tx_req <= afd_tx_hungry(32'(tx_count), BYTES);
        dma_rx_req <= afd_rx_loaded(32'(rx_count), BYTES);
      end
    end
  end

  assert_tx_req_R1: assert property (@(posedge clk) disable iff (!rst_n || srst)
    ($past(cold_rst_en) && $past(tx_count) >= CW'(HALF)) |-> !dma_tx_req);
  assert_tx_req_low_R1: assert property (@(posedge clk) disable iff (!rst_n || srst)
    ($past(cold_rst_en) && $past(tx_empty)) |-> dma_tx_req);
  assert_rx_req_R2: assert property (@(posedge clk) disable iff (!rst_n || srst)
    ($past(cold_rst_en) && $past(rx_full)) |-> dma_rx_req);
  assert_rx_req_low_R2: assert property (@(posedge clk) disable iff (!rst_n || srst)
    ($past(cold_rst_en) && $past(rx_empty)) |-> !dma_rx_req);
  assert_cold_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!codec_rst_n && !dma_tx_req && !dma_rx_req));
endmodule

// File: tb/sim_audio_fifo_dma_ctrl.sv
`timescale 1ns/1ps
module sim_audio_fifo_dma_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, cold_rst_en;
  logic        codec_rst_n;
  logic        dma_tx_wr;
  logic [31:0] dma_tx_wdata;
  logic        dma_tx_req;
  logic        dma_rx_rd;
  logic [31:0] dma_rx_rdata;
  logic        dma_rx_req;
  logic        link_tx_take;
  logic [31:0] link_tx_sample;
  logic        link_tx_underrun;
  logic        link_rx_put, link_rx_valid;
  logic [31:0] link_rx_sample;
  logic        link_rx_overrun;

  int errors = 0;
  int checks = 0;
  logic [31:0] rxq[$];

  always #2.5 clk = ~clk;

  audio_fifo_dma_ctrl u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    dma_tx_wr = 0; dma_rx_rd = 0; link_tx_take = 0; link_rx_put = 0; link_rx_valid = 0;
  endtask

  task automatic tx_write(logic [31:0] v);
    dma_tx_wr = 1; dma_tx_wdata = v; tick(); dma_tx_wr = 0;
  endtask

  task automatic tx_take_check(string req, logic [31:0] exp);
    link_tx_take = 1; #1; chk(req, link_tx_sample, exp); tick(); link_tx_take = 0;
  endtask

  task automatic rx_put(logic valid, logic [31:0] v);
    link_rx_put = 1; link_rx_valid = valid; link_rx_sample = v;
    rxq.push_back(valid ? v : 32'h0);
    tick(); link_rx_put = 0; link_rx_valid = 0;
  endtask

  task automatic cold_cycle();
    idle(); cold_rst_en = 0; tick(); tick(); cold_rst_en = 1; tick();
    rxq.delete();
  endtask

  task automatic t_reset_state();
    chk("R3 codec reset held", 32'(codec_rst_n), 0);
    chk("R3 tx req low", 32'(dma_tx_req), 0);
    chk("R3 rx req low", 32'(dma_rx_req), 0);
    chk("R3 flags clear", {30'h0, link_tx_underrun, link_rx_overrun}, 0);
    chk("R3 rx data zero", dma_rx_rdata, 0);
  endtask

  task automatic t_tx_stream();
    cold_rst_en = 1; tick();
    chk("R3 codec released", 32'(codec_rst_n), 1);
    chk("R1 tx req after release", 32'(dma_tx_req), 1);
    for (int i = 0; i < 7; i++) tx_write(32'hA0 + 32'(i));
    tx_take_check("R4 zero before half", 32'h0);
    chk("R4 no underrun prestream", 32'(link_tx_underrun), 0);
    tx_write(32'hA7);
    chk("R1 req lags count", 32'(dma_tx_req), 1);
    tick();
    chk("R1 req drops at 32 bytes", 32'(dma_tx_req), 0);
    for (int i = 0; i < 8; i++) tx_take_check("R5 fifo order", 32'hA0 + 32'(i));
    chk("R1 req back after drain", 32'(dma_tx_req), 1);
    tx_take_check("R6 zero on starve", 32'h0);
    chk("R6 underrun set", 32'(link_tx_underrun), 1);
    tick();
    chk("R6 underrun sticky", 32'(link_tx_underrun), 1);
  endtask

  task automatic t_tx_full_drop();
    cold_cycle();
    for (int i = 0; i < 17; i++) tx_write(32'hB0 + 32'(i));
    tick();
    for (int i = 0; i < 16; i++) tx_take_check("R10 kept entries", 32'hB0 + 32'(i));
    tx_take_check("R10 extra write dropped", 32'h0);
    chk("R10 underrun after 16", 32'(link_tx_underrun), 1);
  endtask

  task automatic t_rx_path();
    cold_cycle();
    for (int i = 0; i < 3; i++) rx_put(1'b0, 32'hDEAD0000 + 32'(i));
    for (int i = 3; i < 8; i++) rx_put(1'b1, 32'hC0 + 32'(i));
    chk("R2 req lags count", 32'(dma_rx_req), 0);
    tick();
    chk("R2 req at 32 bytes", 32'(dma_rx_req), 1);
    for (int i = 0; i < 3; i++) begin
      link_rx_put = 1; link_rx_valid = 1; link_rx_sample = 32'hD0 + 32'(i);
      dma_rx_rd = 1; #1;
      chk("R7 invalid stored as zero", dma_rx_rdata, rxq.pop_front());
      rxq.push_back(32'hD0 + 32'(i));
      tick(); idle();
      chk("R9 req steady on push+pop", 32'(dma_rx_req), 1);
    end
    for (int i = 0; i < 8; i++) rx_put(1'b1, 32'hE0 + 32'(i));
    link_rx_put = 1; link_rx_valid = 1; link_rx_sample = 32'hF0; dma_rx_rd = 1; #1;
    chk("R9 head at full", dma_rx_rdata, rxq.pop_front());
    rxq.push_back(32'hF0);
    tick(); idle();
    chk("R9 no overrun on push+pop at full", 32'(link_rx_overrun), 0);
    link_rx_put = 1; link_rx_valid = 1; link_rx_sample = 32'hF1; tick(); idle();
    chk("R8 overrun set", 32'(link_rx_overrun), 1);
    for (int i = 0; i < 16; i++) begin
      dma_rx_rd = 1; #1;
      chk("R7 R8 drain order", dma_rx_rdata, rxq.pop_front());
      tick(); dma_rx_rd = 0;
    end
    tick();
    chk("R2 req low when empty", 32'(dma_rx_req), 0);
    dma_rx_rd = 1; #1;
    chk("R11 empty reads zero", dma_rx_rdata, 0);
    tick(); dma_rx_rd = 0;
    rx_put(1'b1, 32'h5A5A);
    #1; chk("R11 empty read ignored", dma_rx_rdata, rxq.pop_front());
    chk("R8 overrun sticky", 32'(link_rx_overrun), 1);
  endtask

  task automatic t_midrun_reset();
    for (int i = 0; i < 9; i++) rx_put(1'b1, 32'h77);
    tick();
    cold_rst_en = 0; tick();
    chk("R3 codec reasserted", 32'(codec_rst_n), 0);
    chk("R3 reqs cleared", {30'h0, dma_tx_req, dma_rx_req}, 0);
    chk("R3 overrun cleared", 32'(link_rx_overrun), 0);
    chk("R3 rx emptied", dma_rx_rdata, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 0; cold_rst_en = 0; dma_tx_wdata = 0; link_rx_sample = 0;
    idle();
    tick(); tick();
    rst_n = 1;
    tick(); tick();
    t_reset_state();
    t_tx_stream();
    t_tx_full_drop();
    t_rx_path();
    t_midrun_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule